// File: doc/BRIEF.md
# Single-Step Reciprocal Unit With Squared-Seed Table

This block returns the reciprocal of an unsigned fixed-point operand that is already scaled into [1, 2). It refines a table seed with one Newton–Raphson step. A second table holds the square of each seed, so the refinement 2·x0 − d·x0² needs one multiply and one subtract. The whole computation fits between the input handshake and a single output register.

Operands enter on a valid/ready stream and results leave on another. A result is offered one clock after its operand is accepted. The output stage holds one result. When the downstream side stalls, the result is held and no new operand is taken. The operand has one integer bit and `IN_FRAC` fraction bits. The result is a pure fraction of `OUT_FRAC` bits.

Top module: `recip_nr1`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: An operand accepted at a clock edge (`in_valid` and `in_ready` both 1) is presented on `out_valid`/`out_data` from that edge on. At most one result is pending at any time.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` keeps its value at the following edges.
- R4: `in_ready` is 1 exactly when no result is pending or the pending one is being taken in the same cycle. A pending result that is taken with no new operand leaves `out_valid` 0.
- R5: The table index is the five fraction bits just below the integer bit of the operand. For index k, the seed is round(4096 / (65 + 2k)) / 64. That is the reciprocal of the interval midpoint, held as 6 fraction bits. The second table stores the exact 12-bit square of that seed.
- R6: The result equals 2·x0 − d·x0², computed exactly and rounded to the nearest multiple of 2^−OUT_FRAC, half up.
- R7: The result lies in [0.5, 1). Its top bit is always set. A rounded value reaching 1.0 is replaced by the all-ones code.
- R8: Over every operand in [1, 2), the largest absolute error against 1/d is at most 0.0017. The mean absolute error is at most 0.00044.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present on `in_data` |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_data | input | IN_FRAC+1 | Operand d, one integer bit then IN_FRAC fraction bits, in [1, 2) |
| out_valid | output | 1 | Result present on `out_data` |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_data | output | OUT_FRAC | Result 1/d as a fraction of OUT_FRAC bits |

## Verification
The checks assume that every operand offered with `in_valid` high has its integer bit set, so it lies in [1, 2). Range scaling happens upstream, and the result-range property holds only under that condition. The stimulus creates every operand as 2^IN_FRAC plus an offset below 2^IN_FRAC, so no out-of-range value is ever driven. The sweep first presents each of the 4096 operands once with the output always taken. It then repeats a strided subset with gaps in `in_valid` and stalls on `out_ready`, to exercise holding and draining.

// File: rtl/recip_pkg.sv
package recip_pkg;

  // Seed for table index k: reciprocal of the interval midpoint,
  // rounded to nearest, as a fraction of seed_w bits.
  function automatic int unsigned seed_of(int unsigned k, int unsigned addr_w,
                                          int unsigned seed_w);
    int unsigned num;
    int unsigned den;
    int unsigned s;
    num = 32'd1 << (seed_w + addr_w + 1);
    den = (32'd1 << (addr_w + 1)) + 2 * k + 1;
    s   = (2 * num + den) / (2 * den);
    if (s > (32'd1 << seed_w) - 1) s = (32'd1 << seed_w) - 1;
    return s;
  endfunction

endpackage

// File: rtl/recip_seed_lut.sv
module recip_seed_lut #(
  parameter int ADDR_W = 5,
  parameter int SEED_W = 6
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [SEED_W-1:0]   seed,
  output logic [2*SEED_W-1:0] seed_sq
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SQ_W  = 2 * SEED_W;

  logic [SEED_W-1:0] seed_tbl [DEPTH];
  logic [SQ_W-1:0]   sq_tbl   [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    localparam int unsigned SV = recip_pkg::seed_of(k, ADDR_W, SEED_W);
    assign seed_tbl[k] = SEED_W'(SV);
    assign sq_tbl[k]   = SQ_W'(SV * SV);
  end

  assign seed    = seed_tbl[addr];
  assign seed_sq = sq_tbl[addr];
endmodule

// File: rtl/recip_refine.sv
module recip_refine #(
  parameter int IN_FRAC  = 12,
  parameter int SEED_W   = 6,
  parameter int OUT_FRAC = 16
) (
  input  logic [IN_FRAC:0]    d,
  input  logic [SEED_W-1:0]   seed,
  input  logic [2*SEED_W-1:0] seed_sq,
  output logic [OUT_FRAC-1:0] res
);
  localparam int SCALE = IN_FRAC + 2 * SEED_W;   // fraction bits of exact result
  localparam int ACC_W = SCALE + 2;
  localparam int SH    = SCALE - OUT_FRAC;       // must be >= 1

  logic [ACC_W-1:0] two_x0;
  logic [ACC_W-1:0] d_x0sq;
  logic [ACC_W-1:0] diff;
  logic [ACC_W-1:0] rnd;
  logic [ACC_W-1:0] q;

  always_comb begin
    two_x0 = ACC_W'(seed) << (IN_FRAC + SEED_W + 1);
    d_x0sq = ACC_W'(d) * ACC_W'(seed_sq);
    diff   = two_x0 - d_x0sq;
    rnd    = diff + (ACC_W'(1) << (SH - 1));
    q      = rnd >> SH;
    if (q > ACC_W'((1 << OUT_FRAC) - 1)) res = '1;
    else                                 res = q[OUT_FRAC-1:0];
  end
endmodule

// File: rtl/recip_nr1.sv
module recip_nr1 #(
  parameter int IN_FRAC  = 12,
  parameter int OUT_FRAC = 16,
  parameter int ADDR_W   = 5,
  parameter int SEED_W   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [IN_FRAC:0]    in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [OUT_FRAC-1:0] out_data
);
  logic [ADDR_W-1:0]   addr;
  logic [SEED_W-1:0]   seed;
  logic [2*SEED_W-1:0] seed_sq;
  logic [OUT_FRAC-1:0] res;
  logic                take;

  assign addr     = in_data[IN_FRAC-1 -: ADDR_W];
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  recip_seed_lut #(.ADDR_W(ADDR_W), .SEED_W(SEED_W)) u_lut (
    .addr    (addr),
    .seed    (seed),
    .seed_sq (seed_sq)
  );

  recip_refine #(.IN_FRAC(IN_FRAC), .SEED_W(SEED_W), .OUT_FRAC(OUT_FRAC)) u_refine (
    .d       (in_data),
    .seed    (seed),
    .seed_sq (seed_sq),
    .res     (res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take)     out_data  <= res;
    end
  end
endmodule

// File: rtl/recip_nr1_chk.sv
module recip_nr1_chk #(
  parameter int IN_FRAC  = 12,
  parameter int OUT_FRAC = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [IN_FRAC:0]    in_data,
  input logic                out_valid,
  input logic                out_ready,
  input logic [OUT_FRAC-1:0] out_data
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R2
  accept_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R4
  drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R7 (operand contract: integer bit set)
  operand_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> in_data[IN_FRAC]);

  // R7
  result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data[OUT_FRAC-1]);
endmodule

bind recip_nr1 recip_nr1_chk #(.IN_FRAC(IN_FRAC), .OUT_FRAC(OUT_FRAC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/sim_recip_nr1.sv
module sim_recip_nr1;
  localparam int CLK_PERIOD = 10;
  localparam int IN_FRAC  = 12;
  localparam int OUT_FRAC = 16;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic                in_ready;
  logic [IN_FRAC:0]    in_data = '0;
  logic                out_valid;
  logic                out_ready = 1'b0;
  logic [OUT_FRAC-1:0] out_data;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  finished = 0;

  logic [OUT_FRAC-1:0] exp_q [$];
  int                  dval_q [$];
  bit                  hold_pend = 0;
  logic [OUT_FRAC-1:0] hold_data = '0;
  bit                  collect = 0;
  real                 err_sum = 0.0;
  real                 err_max = 0.0;
  int                  err_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  recip_nr1 #(.IN_FRAC(IN_FRAC), .OUT_FRAC(OUT_FRAC)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  // Expected result from R5/R6/R7 for operand dv (scaled by 2^12).
  function automatic logic [OUT_FRAC-1:0] expect_of(int dv);
    longint k, den, s, sq, diff, q;
    k    = (dv >> 7) & 31;
    den  = 65 + 2 * k;
    s    = (8192 + den) / (2 * den);
    sq   = s * s;
    diff = (s << 19) - longint'(dv) * sq;
    q    = (diff + 128) >>> 8;
    if (q > 65535) q = 65535;
    return OUT_FRAC'(q);
  endfunction

  task automatic check(bit ok, string req, longint act, longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // One cycle: drive, then evaluate the handshake at the coming edge.
  task automatic step(bit iv, int dv, bit ordy, output bit accepted);
    real e;
    @(negedge clk);
    in_valid  = iv;
    in_data   = (IN_FRAC+1)'(dv);
    out_ready = ordy;
    #1;
    if (hold_pend) begin
      check(out_valid == 1'b1, "R3 valid held", out_valid, 1);
      check(out_data == hold_data, "R3 data held", out_data, hold_data);
    end
    check(out_valid == (exp_q.size() != 0), "R2 pending", out_valid, exp_q.size());
    check(in_ready == (!out_valid || out_ready), "R4 ready", in_ready, !out_valid || out_ready);
    if (out_valid && out_ready && exp_q.size() != 0) begin
      logic [OUT_FRAC-1:0] ev;
      int                  d0;
      ev = exp_q.pop_front();
      d0 = dval_q.pop_front();
      check(out_data == ev, "R6 result", out_data, ev);
      check(out_data[OUT_FRAC-1] == 1'b1, "R7 range", out_data, 32768);
      if (collect) begin
        e = real'(out_data) / 65536.0 - 4096.0 / real'(d0);
        if (e < 0.0) e = -e;
        err_sum += e;
        if (e > err_max) err_max = e;
        err_n++;
      end
    end
    hold_pend = out_valid && !out_ready;
    hold_data = out_data;
    accepted = iv && in_ready;
    if (accepted) begin
      exp_q.push_back(expect_of(dv));
      dval_q.push_back(dv);
    end
  endtask

  initial begin
    bit acc;
    int idx;
    int cyc;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);

    // Full sweep, output always taken (R2, R5, R6, R7, R8)
    collect = 1;
    for (int i = 0; i < 4096; i++) step(1'b1, 4096 + i, 1'b1, acc);
    step(1'b0, 4096, 1'b1, acc);
    collect = 0;
    check(err_n == 4096, "R8 sample count", err_n, 4096);
    check(err_max <= 0.0017, "R8 max error x1e6", longint'(err_max * 1.0e6), 1700);
    check(err_sum / 4096.0 <= 0.00044, "R8 mean error x1e6",
          longint'(err_sum / 4096.0 * 1.0e6), 440);

    // Gaps and stalls (R2, R3, R4)
    idx = 0;
    cyc = 0;
    while (idx < 600) begin
      step((cyc % 3) != 1, 4096 + (idx * 37) % 4096, ((cyc / 2) % 3) != 0, acc);
      if (acc) idx++;
      cyc++;
    end
    // Drain with no new operand: R4 drain then empty
    step(1'b0, 4096, 1'b1, acc);
    step(1'b0, 4096, 1'b1, acc);
    check(out_valid == 1'b0, "R4 drained", out_valid, 0);
    check(exp_q.size() == 0, "R2 nothing lost", exp_q.size(), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule